// File: doc/BRIEF.md
# ROM Entry List Walker

This block walks the chain of variable-length records that sits after the fixed 22-byte header of a device configuration ROM image. A controller first copies the image into a byte-addressed buffer. It then pulses `start` together with the image's data-length field. The walker reads the buffer through a synchronous read port with one cycle of latency. Each record's first byte gives its length, and the walker uses it to step to the next record.

Records of the port kind update a per-port configuration table with one entry for each of the 64 port indices that a record can name. A disabled record only sets a flag. An enabled record also stores a link number and an optional dual-link partner. Records of the generic kind are stepped over. A malformed chain stops the walk with an error code. The table is cleared when a walk starts, and it is read back through a registered lookup port.

Top module: `rom_entry_walker`

## Requirements
- R1: A `start` pulse while idle latches the image size as `data_len` + 13 and begins the walk at byte offset 22. A `start` pulse while busy has no effect on the walk in progress or on its result.
- R2: Every buffer read uses an address that is at least 22 and below the latched image size. The byte appears on `rom_data` in the cycle after `rom_rd` was high.
- R3: Byte 0 of a record is its length in bytes. In byte 1, bits 5:0 hold the port index, bit 6 is the disabled flag and bit 7 is the kind (1 = port, 0 = generic). A generic record leaves the table unchanged, whatever its other bits hold, and the walk continues at position + length.
- R4: The walk ends with `err` = 1 (overrun) when the position is the last byte of the image, when the length is zero, or when position + length exceeds the image size. Records applied before that point stay in the table.
- R5: A port record with the disabled flag set marks that index as disabled and is counted. Its link and partner fields keep their previous contents, and no further bytes of the record are read. Its length may be any value that passes R4.
- R6: An enabled port record whose length is not 8 ends the walk with `err` = 2 (size error). That record does not change the table.
- R7: An enabled port record of length 8 clears the index's disabled flag and is counted. It stores the link number from byte 2 bit 4 and the partner-valid flag from byte 2 bit 7. It stores the partner number from byte 3 bits 5:0 when the partner-valid flag is set, and 0 when it is not.
- R8: Starting a walk clears every table entry, so that all fields read back as zero until a record writes them.
- R9: The walk ends normally with `err` = 0 when the position equals the image size. `done` is high for exactly one cycle at the end of every walk. `port_count` then holds the number of port records applied. `err` and `port_count` hold their values until the next start.
- R10: The lookup outputs show the entry selected by `q_idx` one clock cycle after `q_idx` is presented.
- R11: A walk over n records raises `done` within 6n + 4 cycles of the cycle in which `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| data_len | input | LEN_W | Data-length field of the image header |
| rom_rd | output | 1 | Buffer read enable |
| rom_addr | output | LEN_W+1 | Buffer byte address |
| rom_data | input | 8 | Buffer byte, valid the cycle after the read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 2 | 0 none, 1 overrun, 2 size error |
| port_count | output | LEN_W+1 | Port records applied in the last walk |
| q_idx | input | 6 | Table lookup index |
| q_disabled | output | 1 | Disabled flag of the entry |
| q_link | output | 1 | Link number of the entry |
| q_partner_vld | output | 1 | Partner-valid flag of the entry |
| q_partner | output | 6 | Partner port number of the entry |

## Verification
The bench builds the walker with LEN_W = 7, so the largest image is 140 bytes. Images that fill the buffer exactly, and records that overrun its last byte, can then be built by hand and walked in a few hundred cycles.

The bench sweeps all 256 values of the record flag byte behind a known prior record. It sweeps enabled-record lengths from 0 to 20 across the size-error and overrun boundaries. It also walks mixed chains that repeat port indices. After every walk it reads back all 64 table entries and compares them with values derived from the record bytes.

// File: rtl/rew_pkg.sv
package rew_pkg;
  localparam int IDX_W = 6;        // port index width fixed by the record format
  localparam int ENTRY_BYTES = 8;  // length of an enabled port record

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_OVERRUN = 2'd1,
    ERR_SIZE    = 2'd2
  } rew_err_e;

  typedef struct packed {
    logic             link;
    logic             pvld;
    logic [IDX_W-1:0] partner;
  } rew_cfg_t;
endpackage

// File: rtl/rew_table.sv
module rew_table
  import rew_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_dis,
  input  logic             wr_cfg,
  input  logic [IDX_W-1:0] wr_idx,
  input  rew_cfg_t         wr_data,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_dis,
  output rew_cfg_t         q_cfg
);
  localparam int DEPTH = 1 << IDX_W;

  rew_cfg_t         mem [DEPTH];
  rew_cfg_t         mem_q;
  logic [DEPTH-1:0] set_v;
  logic [DEPTH-1:0] dis_v;
  logic             set_q;
  logic             dis_q;

  // Field storage: no reset, one write port, registered read
  always_ff @(posedge clk) begin
    if (wr_cfg) mem[wr_idx] <= wr_data;
    mem_q <= mem[q_idx];
  end

  // Flag vectors cleared in a single cycle at walk start
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      set_v <= '0;
      dis_v <= '0;
    end else begin
      if (wr_cfg) begin
        set_v[wr_idx] <= 1'b1;
        dis_v[wr_idx] <= 1'b0;
      end
      if (wr_dis) dis_v[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      set_q <= set_v[q_idx];
      dis_q <= dis_v[q_idx];
    end
  end

  assign q_dis = dis_q;
  assign q_cfg = set_q ? mem_q : '0;

  // R5 R7: a record applies either the disabled mark or the full fields
  a_r5_one_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_dis && wr_cfg));
endmodule

// File: rtl/rew_ctrl.sv
module rew_ctrl
  import rew_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int HDR_BYTES  = 22,
  parameter int DATA_START = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] data_len,
  output logic             rom_rd,
  output logic [LEN_W:0]   rom_addr,
  input  logic [7:0]       rom_data,
  output logic             clr,
  output logic             wr_dis,
  output logic             wr_cfg,
  output logic [IDX_W-1:0] wr_idx,
  output rew_cfg_t         wr_data,
  output logic             busy,
  output logic             done,
  output rew_err_e         err,
  output logic [LEN_W:0]   count
);
  localparam int AW = LEN_W + 1;
  localparam int PW = ((AW > 8) ? AW : 8) + 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LEN, S_B1, S_B2, S_B3} st_e;

  st_e              st;
  logic [AW-1:0]    size_q, pos_q, next_pos;
  logic [7:0]       len_q;
  logic [IDX_W-1:0] idx_q;
  logic             link_q, pvld_q;
  logic [PW-1:0]    pos_x, size_x, end_x;
  logic             at_end, last_byte, bad_len, port_ent, dis_ent, full_ent;

  always_comb begin
    pos_x     = PW'(pos_q);
    size_x    = PW'(size_q);
    end_x     = pos_x + PW'(rom_data);
    at_end    = pos_x >= size_x;
    last_byte = (pos_x + PW'(1)) == size_x;
    bad_len   = (rom_data == 8'd0) || (end_x > size_x);
    port_ent  = rom_data[7];
    dis_ent   = rom_data[6];
    full_ent  = port_ent && !dis_ent && (len_q == 8'(ENTRY_BYTES));
    next_pos  = pos_q + AW'(len_q);
  end

  // Read port: address offset selected by the record byte being fetched
  always_comb begin
    rom_rd   = 1'b0;
    rom_addr = pos_q;
    case (st)
      S_FETCH: rom_rd = !at_end && !last_byte;
      S_LEN:   begin rom_rd = !bad_len;  rom_addr = pos_q + AW'(1); end
      S_B1:    begin rom_rd = full_ent;  rom_addr = pos_q + AW'(2); end
      S_B2:    begin rom_rd = 1'b1;      rom_addr = pos_q + AW'(3); end
      default: ;
    endcase
  end

  assign clr     = (st == S_IDLE) && start;
  assign wr_dis  = (st == S_B1) && port_ent && dis_ent;
  assign wr_cfg  = (st == S_B3);
  assign wr_idx  = (st == S_B3) ? idx_q : rom_data[IDX_W-1:0];
  assign wr_data = '{link: link_q, pvld: pvld_q,
                     partner: pvld_q ? rom_data[IDX_W-1:0] : '0};
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      err    <= ERR_NONE;
      count  <= '0;
      size_q <= '0;
      pos_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      link_q <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          size_q <= AW'(data_len) + AW'(DATA_START);
          pos_q  <= AW'(HDR_BYTES);
          count  <= '0;
          err    <= ERR_NONE;
          st     <= S_FETCH;
        end
        S_FETCH: begin
          if (at_end) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (last_byte) begin
            err  <= ERR_OVERRUN;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_LEN;
          end
        end
        S_LEN: begin
          len_q <= rom_data;
          if (bad_len) begin
            err  <= ERR_OVERRUN;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_B1;
          end
        end
        S_B1: begin
          idx_q <= rom_data[IDX_W-1:0];
          if (!port_ent) begin
            pos_q <= next_pos;
            st    <= S_FETCH;
          end else if (dis_ent) begin
            count <= count + AW'(1);
            pos_q <= next_pos;
            st    <= S_FETCH;
          end else if (!full_ent) begin
            err  <= ERR_SIZE;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_B2;
          end
        end
        S_B2: begin
          link_q <= rom_data[4];
          pvld_q <= rom_data[7];
          st     <= S_B3;
        end
        S_B3: begin
          count <= count + AW'(1);
          pos_q <= next_pos;
          st    <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_addr_in_image: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> (rom_addr >= AW'(HDR_BYTES) && rom_addr < size_q));

  a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(size_q));

  a_r4_zero_len_overrun: assert property (@(posedge clk) disable iff (rst)
    (st == S_LEN && rom_data == 8'd0) |=> (done && err == ERR_OVERRUN));

  a_r6_size_error: assert property (@(posedge clk) disable iff (rst)
    (st == S_B1 && rom_data[7:6] == 2'b10 && len_q != 8'(ENTRY_BYTES))
      |=> (done && err == ERR_SIZE));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
  import rew_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int HDR_BYTES  = 22,
  parameter int DATA_START = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] data_len,
  output logic             rom_rd,
  output logic [LEN_W:0]   rom_addr,
  input  logic [7:0]       rom_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic [LEN_W:0]   port_count,
  input  logic [5:0]       q_idx,
  output logic             q_disabled,
  output logic             q_link,
  output logic             q_partner_vld,
  output logic [5:0]       q_partner
);
  logic             clr, wr_dis, wr_cfg;
  logic [IDX_W-1:0] wr_idx;
  rew_cfg_t         wr_data, q_cfg;
  rew_err_e         err_e;

  rew_ctrl #(
    .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES), .DATA_START(DATA_START)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .data_len(data_len),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .clr(clr), .wr_dis(wr_dis), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err_e),
    .count(port_count)
  );

  rew_table u_table (
    .clk(clk), .rst(rst), .clr(clr), .wr_dis(wr_dis), .wr_cfg(wr_cfg),
    .wr_idx(wr_idx), .wr_data(wr_data), .q_idx(q_idx),
    .q_dis(q_disabled), .q_cfg(q_cfg)
  );

  assign err           = err_e;
  assign q_link        = q_cfg.link;
  assign q_partner_vld = q_cfg.pvld;
  assign q_partner     = q_cfg.partner;
endmodule

// File: tb/rom_entry_walker_test.sv
`timescale 1ns/1ps
module rom_entry_walker_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [6:0] data_len = '0;
  logic       rom_rd;
  logic [7:0] rom_addr;
  logic [7:0] rom_data;
  logic       busy, done;
  logic [1:0] err;
  logic [7:0] port_count;
  logic [5:0] q_idx = '0;
  logic       q_disabled, q_link, q_partner_vld;
  logic [5:0] q_partner;

  always #5 clk = ~clk;

  rom_entry_walker #(.LEN_W(7)) uut (
    .clk(clk), .rst(rst), .start(start), .data_len(data_len),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .busy(busy), .done(done), .err(err), .port_count(port_count),
    .q_idx(q_idx), .q_disabled(q_disabled), .q_link(q_link),
    .q_partner_vld(q_partner_vld), .q_partner(q_partner)
  );

  logic [7:0] rom [256];
  always @(posedge clk) if (rom_rd) rom_data <= rom[rom_addr];

  int n_chk = 0, n_bad = 0, addr_viol = 0, cur_size = 0;
  logic       exp_dis [64];
  logic       exp_link [64];
  logic       exp_pv [64];
  logic [5:0] exp_pn [64];
  int exp_cnt, n_ent, wptr;

  // R2 address window monitor
  always @(negedge clk)
    if (!rst && rom_rd && (int'(rom_addr) < 22 || int'(rom_addr) >= cur_size))
      addr_viol++;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic new_img();
    for (int i = 0; i < 256; i++) rom[i] = 8'hEE;
    for (int i = 0; i < 64; i++) begin
      exp_dis[i] = 1'b0; exp_link[i] = 1'b0; exp_pv[i] = 1'b0; exp_pn[i] = '0;
    end
    exp_cnt = 0; n_ent = 0; wptr = 22;
  endtask

  // Places one record and applies its specified effect to the expectation
  task automatic put_raw(input int len, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3);
    int ix;
    ix = int'(b1[5:0]);
    rom[wptr] = 8'(len);
    rom[wptr+1] = b1;
    if (len > 2) rom[wptr+2] = b2;
    if (len > 3) rom[wptr+3] = b3;
    for (int k = 4; k < len; k++) rom[wptr+k] = 8'h3C;
    n_ent++;
    if (b1[7]) begin
      if (b1[6]) begin
        exp_dis[ix] = 1'b1;
        exp_cnt++;
      end else if (len == 8) begin
        exp_dis[ix] = 1'b0;
        exp_link[ix] = b2[4];
        exp_pv[ix] = b2[7];
        exp_pn[ix] = b2[7] ? b3[5:0] : 6'd0;
        exp_cnt++;
      end
    end
    wptr += len;
  endtask

  task automatic put_port(input int idx, input bit dis, input bit link, input bit pv,
                          input int pn);
    put_raw(dis ? 3 : 8, {1'b1, dis, 6'(idx)}, {pv, 2'b10, link, 4'h6},
            {2'b01, 6'(pn)});
  endtask

  task automatic put_gen(input int len);
    put_raw(len, {2'b01, 6'd9}, 8'hFF, 8'hFF);
  endtask

  task automatic chk_table();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk) q_idx = 6'(i);
      @(negedge clk);
      chk({q_disabled, q_link, q_partner_vld, q_partner} ==
          {exp_dis[i], exp_link[i], exp_pv[i], exp_pn[i]},
          "R3 R5 R7 R8 R10 table entry",
          int'({q_disabled, q_link, q_partner_vld, q_partner}),
          int'({exp_dis[i], exp_link[i], exp_pv[i], exp_pn[i]}));
    end
  endtask

  task automatic run(input int dl, input logic [1:0] e_err, input string tag,
                     input bit poke);
    int cyc;
    cur_size = dl + 13;
    @(negedge clk); start = 1'b1; data_len = 7'(dl);
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin start = 1'b1; data_len = 7'h7F; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(err == e_err, tag, int'(err), int'(e_err));
    chk(int'(port_count) == exp_cnt, "R9 port count", int'(port_count), exp_cnt);
    chk(cyc <= 6 * n_ent + 4, "R11 walk cycles", cyc, 6 * n_ent + 4);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk_table();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    new_img();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); q_idx = 6'd5;
    @(negedge clk);
    chk({busy, done, err, port_count} == '0, "R9 reset outputs",
        int'({busy, done, err, port_count}), 0);
    chk({q_disabled, q_link, q_partner_vld, q_partner} == '0, "R8 reset table",
        int'({q_disabled, q_link, q_partner_vld, q_partner}), 0);

    // R9: header only, nothing to walk
    new_img();
    run(9, 2'd0, "R9 empty list", 1'b0);

    // R3 R5 R7: every flag byte value behind a known prior record
    for (int b = 0; b < 256; b++) begin
      logic [7:0] b1;
      b1 = 8'(b);
      new_img();
      put_port(int'(b1[5:0]), 1'b0, 1'b1, 1'b1, int'(b1[5:0] ^ 6'h15));
      put_raw(8, b1, b1 ^ 8'h5A, ~b1);
      run(wptr - 13, 2'd0, "R3 flag sweep err", 1'b0);
    end

    // R4 R6: enabled record length across the boundaries
    for (int l = 0; l <= 20; l++) begin
      logic [1:0] e;
      new_img();
      put_raw(l, 8'h83, 8'h90, 8'h05);
      if (l == 8) begin
        put_gen(8);
        e = 2'd0;
      end else if (l == 0 || l > 16) e = 2'd1;
      else e = 2'd2;
      run(25, e, (l == 0 || l > 16) ? "R4 length overrun" :
                 (l == 8) ? "R7 length eight" : "R6 size error", 1'b0);
    end

    // R4: position lands on the final byte
    new_img();
    put_port(7, 1'b0, 1'b1, 1'b0, 0);
    rom[wptr] = 8'h05;
    run(wptr + 1 - 13, 2'd1, "R4 last byte", 1'b0);

    // R4: record end one past the image
    new_img();
    put_port(3, 1'b0, 1'b0, 1'b1, 44);
    put_gen(8);
    run(wptr - 1 - 13, 2'd1, "R4 end past size", 1'b0);

    // R1 R9: largest image, start pulsed mid-walk
    new_img();
    for (int k = 0; k < 14; k++)
      put_port((k * 5) % 64, (k % 3) == 0, k[0], (k % 2) == 0, (k * 13) % 64);
    put_gen(140 - wptr);
    run(127, 2'd0, "R1 full image busy start", 1'b1);

    // R5 R7 R8: mixed chains with repeated indices
    for (int r = 0; r < 16; r++) begin
      new_img();
      for (int k = 0; k < (r % 8) + 3; k++) begin
        if ((r + k) % 5 == 2) put_gen(2 + k);
        else put_port((r + k * 3) % 8, ((r + k) % 4) == 1, k[1], (r + k) % 2 == 0,
                      (r * 7 + k) % 64);
      end
      run(wptr - 13, 2'd0, "R5 mixed chain", r[0]);
    end

    chk(addr_viol == 0, "R2 read window", addr_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule